// File: doc/BRIEF.md
# Clock-Generator Control Register Slave on a Two-Wire System Bus

This block is the control port of a clock generator. It sits on a two-wire SMBus segment as a slave and holds seven byte-wide control registers. Their contents leave the block in parallel and drive output enables, mode selects and edge-rate controls elsewhere in the chip. SDA is open-drain. The block models it as an output-enable, and a high `sda_oe` pulls the line low.

Only two transfer types are understood. In the block write, the address byte carries a write bit. The host then sends a command byte and a byte count, and both are accepted and thrown away. After them the data bytes fill the registers from index 0 upward. In the block read, the address byte carries a read bit. The slave answers with a byte count of 7 and then returns all seven registers in index order.

Some bits are read-only. They show board straps that are captured while reset is held, plus a fixed identity byte. Both lines pass through a synchroniser and an edge detector running on the system clock. That clock must be at least ten times the bus clock.

Top module: `smb_blk_regfile`

## Requirements
- R1: While `rst` is high, register i is loaded with its default: reg0=0x08, reg1=0x47, reg2=0x7F, reg3=0xC7, reg4=0x3F, reg5=0x00. The strap bits are ORed in, and reg6 = {REV_ID, 4'h1}. Register i appears on `cfg_bytes[8i+7:8i]`.
- R2: The strap bits are captured while `rst` is high and held after reset, whatever the strap pins do later. Reg0 bits 2:1 hold `strap_fs[1:0]` and reg1 bit 7 holds `strap_swing`.
- R3: An address byte of 0xD2 (write) or 0xD3 (read) is acknowledged. Any other address is not acknowledged, and the rest of that transfer changes no register.
- R4: In a write, the two bytes after the address are acknowledged and discarded whatever their values. Each following data byte is acknowledged and loads the next register, starting at reg0.
- R5: A data byte changes only the writable bits. The write masks are reg0 0xA8, reg1 0x47, reg2 0x7F, reg3 0xFF, reg4 0x3F and reg5 0x0F, and reg6 has none. Strap, identity and reserved bits keep their values.
- R6: A stop after any complete byte ends a write. Registers already written keep their new values, and the others are untouched. The next write begins again at reg0.
- R7: A data byte after the seventh in one write is not acknowledged and is not stored.
- R8: A read returns 0x07 first and then reg0 through reg6, each most significant bit first.
- R9: When the host does not acknowledge a read byte, the slave releases SDA and drives nothing until the next start. If the host acknowledges past reg6, further bytes read as 0xFF. A later transfer works normally.
- R10: The slave starts pulling SDA low only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 10x the bus clock |
| rst | input | 1 | Synchronous active-high reset; straps are captured while high |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| sda_oe | output | 1 | High pulls the data line low |
| strap_fs | input | 2 | Frequency-select strap pins |
| strap_swing | input | 1 | Output-swing strap pin |
| cfg_bytes | output | 56 | All seven registers, register i in bits 8i+7:8i |

## Verification
A sequencer that has lost its byte index shows at the ports within one transfer. Read-back data comes out shifted by a byte or begins with the wrong count, and a partial write lands in the wrong register of `cfg_bytes`. A wrong bit counter moves the acknowledge slot, and the host then samples a NACK on the very next byte. An error in a write mask or a strap latch appears on `cfg_bytes` in the cycle after the offending byte's last SCL rise has been synchronised. Reading back through the bus confirms the same value.

// File: rtl/smb_regs_pkg.sv
package smb_regs_pkg;

    localparam int NREG   = 7;
    localparam int IDX_W  = $clog2(NREG + 1);
    localparam int CNT_W  = $clog2(NREG + 3);

    localparam logic [7:0] ADDR_WR   = 8'hD2;
    localparam logic [7:0] ADDR_RD   = 8'hD3;
    localparam logic [3:0] VENDOR_ID = 4'h1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RX_ACK,
        ST_ACK_HOLD,
        ST_TX,
        ST_TX_ACK
    } seq_state_e;

    typedef struct packed {
        seq_state_e         st;
        logic [2:0]         bitcnt;
        logic [7:0]         sh;
        logic [CNT_W-1:0]   idx;
        logic               seen;
        logic               rw;
        logic               ack;
        logic               oe;
    } seq_t;

    // writable bits per register
    function automatic logic [7:0] wr_mask(input int i);
        case (i)
            0:       return 8'hA8;
            1:       return 8'h47;
            2:       return 8'h7F;
            3:       return 8'hFF;
            4:       return 8'h3F;
            5:       return 8'h0F;
            default: return 8'h00;
        endcase
    endfunction

    // power-on value of the writable bits
    function automatic logic [7:0] rst_val(input int i);
        case (i)
            0:       return 8'h08;
            1:       return 8'h47;
            2:       return 8'h7F;
            3:       return 8'hC7;
            4:       return 8'h3F;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_pipe_q, sda_pipe_q;
    logic              scl_p_q, sda_p_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe_q <= '1;
            sda_pipe_q <= '1;
            scl_p_q    <= 1'b1;
            sda_p_q    <= 1'b1;
        end else begin
            scl_pipe_q <= {scl_pipe_q[STAGES-2:0], scl_in};
            sda_pipe_q <= {sda_pipe_q[STAGES-2:0], sda_in};
            scl_p_q    <= scl_pipe_q[STAGES-1];
            sda_p_q    <= sda_pipe_q[STAGES-1];
        end
    end

    assign scl_s     = scl_pipe_q[STAGES-1];
    assign sda_s     = sda_pipe_q[STAGES-1];
    assign scl_rise  = scl_s & ~scl_p_q;
    assign scl_fall  = ~scl_s & scl_p_q;
    assign start_det = scl_s & scl_p_q & sda_p_q & ~sda_s;
    assign stop_det  = scl_s & scl_p_q & ~sda_p_q & sda_s;

endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank
    import smb_regs_pkg::*;
#(
    parameter logic [3:0] REV_ID = 4'h3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        strap_fs,
    input  logic              strap_swing,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [7:0]        wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [7:0]        rd_data,
    output logic [NREG*8-1:0] cfg_flat
);

    logic [1:0] fs_q;
    logic       swing_q;
    logic [7:0] bytes [NREG];

    // straps follow the pins only while reset is held
    always_ff @(posedge clk) begin
        if (rst) begin
            fs_q    <= strap_fs;
            swing_q <= strap_swing;
        end
    end

    for (genvar i = 0; i < NREG; i++) begin : g_byte
        localparam logic [7:0] M = wr_mask(i);
        localparam logic [7:0] D = rst_val(i);
        logic [7:0] q;
        logic [7:0] ro;

        always_ff @(posedge clk) begin
            if (rst)
                q <= D & M;
            else if (wr_en && wr_idx == IDX_W'(i))
                q <= (q & ~M) | (wr_data & M);
        end

        if (i == 0) begin : g_fs
            assign ro = {5'b0, fs_q, 1'b0};
        end else if (i == 1) begin : g_sw
            assign ro = {swing_q, 7'b0};
        end else if (i == NREG - 1) begin : g_id
            assign ro = {REV_ID, VENDOR_ID};
        end else begin : g_none
            assign ro = 8'h00;
        end

        assign bytes[i]          = (q & M) | ro;
        assign cfg_flat[8*i +: 8] = bytes[i];
    end

    always_comb begin
        rd_data = 8'hFF;
        for (int i = 0; i < NREG; i++)
            if (rd_idx == IDX_W'(i)) rd_data = bytes[i];
    end

endmodule

// File: rtl/smb_blk_regfile.sv
module smb_blk_regfile
    import smb_regs_pkg::*;
#(
    parameter logic [3:0] REV_ID      = 4'h3,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    input  logic [1:0]        strap_fs,
    input  logic              strap_swing,
    output logic [NREG*8-1:0] cfg_bytes
);

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx, rd_idx;
    logic [7:0]       wr_data, rd_data, byte_in, tx_byte;
    seq_t             seq_d, seq_q;

    smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    smb_reg_bank #(.REV_ID(REV_ID)) u_bank (
        .clk(clk), .rst(rst), .strap_fs(strap_fs), .strap_swing(strap_swing),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_idx(rd_idx), .rd_data(rd_data), .cfg_flat(cfg_bytes)
    );

    assign byte_in = {seq_q.sh[6:0], sda_s};
    assign rd_idx  = IDX_W'(seq_q.idx - CNT_W'(1));
    assign tx_byte = (seq_q.idx == '0)              ? 8'(NREG) :
                     (seq_q.idx <= CNT_W'(NREG))    ? rd_data  : 8'hFF;

    always_comb begin
        seq_d   = seq_q;
        wr_en   = 1'b0;
        wr_idx  = IDX_W'(seq_q.idx - CNT_W'(2));
        wr_data = byte_in;

        if (start_det) begin
            seq_d.st     = ST_RX;
            seq_d.bitcnt = '0;
            seq_d.seen   = 1'b0;
            seq_d.idx    = '0;
            seq_d.oe     = 1'b0;
        end else if (stop_det) begin
            seq_d.st = ST_IDLE;
            seq_d.oe = 1'b0;
        end else begin
            case (seq_q.st)
                ST_RX: if (scl_rise) begin
                    seq_d.sh     = byte_in;
                    seq_d.bitcnt = seq_q.bitcnt + 3'd1;
                    if (seq_q.bitcnt == 3'd7) begin
                        seq_d.st = ST_RX_ACK;
                        if (!seq_q.seen) begin
                            seq_d.seen = 1'b1;
                            seq_d.idx  = '0;
                            seq_d.rw   = (byte_in == ADDR_RD);
                            seq_d.ack  = (byte_in == ADDR_WR) || (byte_in == ADDR_RD);
                        end else begin
                            seq_d.ack = (seq_q.idx < CNT_W'(NREG + 2));
                            wr_en     = (seq_q.idx >= CNT_W'(2)) &&
                                        (seq_q.idx < CNT_W'(NREG + 2));
                            seq_d.idx = (seq_q.idx == '1) ? seq_q.idx : seq_q.idx + 1'b1;
                        end
                    end
                end
                ST_RX_ACK: if (scl_fall) begin
                    seq_d.oe = seq_q.ack;
                    seq_d.st = seq_q.ack ? ST_ACK_HOLD : ST_IDLE;
                end
                ST_ACK_HOLD: if (scl_fall) begin
                    seq_d.bitcnt = '0;
                    if (seq_q.rw) begin
                        seq_d.sh = tx_byte;
                        seq_d.oe = ~tx_byte[7];
                        seq_d.st = ST_TX;
                    end else begin
                        seq_d.oe = 1'b0;
                        seq_d.st = ST_RX;
                    end
                end
                ST_TX: if (scl_fall) begin
                    if (seq_q.bitcnt == 3'd7) begin
                        seq_d.oe = 1'b0;
                        seq_d.st = ST_TX_ACK;
                    end else begin
                        seq_d.sh     = {seq_q.sh[6:0], 1'b0};
                        seq_d.oe     = ~seq_q.sh[6];
                        seq_d.bitcnt = seq_q.bitcnt + 3'd1;
                    end
                end
                ST_TX_ACK: if (scl_rise) begin
                    if (!sda_s) begin
                        seq_d.idx = (seq_q.idx == '1) ? seq_q.idx : seq_q.idx + 1'b1;
                        seq_d.st  = ST_ACK_HOLD;
                    end else begin
                        seq_d.st = ST_IDLE;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q <= '{st: ST_IDLE, bitcnt: '0, sh: '0, idx: '0,
                       seen: 1'b0, rw: 1'b0, ack: 1'b0, oe: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign sda_oe = seq_q.oe;

endmodule

// File: rtl/smb_blk_regfile_chk.sv
module smb_blk_regfile_chk
    import smb_regs_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              scl_in,
    input logic              sda_oe,
    input logic [NREG*8-1:0] cfg_bytes
);

    logic [NREG*8-1:0] prev_q;
    logic [NREG-1:0]   chg;

    always_ff @(posedge clk) prev_q <= cfg_bytes;

    for (genvar i = 0; i < NREG; i++) begin : g_chg
        assign chg[i] = cfg_bytes[8*i +: 8] != prev_q[8*i +: 8];
    end

    // R4: one data byte updates at most one register per cycle
    a_r4_one_reg_per_cycle: assert property (@(posedge clk) disable iff (rst)
        $onehot0(chg));

    // R4: register updates follow a sampled bit, so SCL is high
    a_r4_update_scl_high: assert property (@(posedge clk) disable iff (rst)
        (chg != '0) |-> scl_in);

    // R2: strap bits keep their captured value once out of reset
    a_r2_strap_hold: assert property (@(posedge clk) disable iff (rst)
        (cfg_bytes[2:1] == prev_q[2:1]) && (cfg_bytes[15] == prev_q[15]));

    // R10: pulling SDA low begins only while SCL is low
    a_r10_drive_scl_low: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_in);

endmodule

bind smb_blk_regfile smb_blk_regfile_chk u_chk (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_oe(sda_oe), .cfg_bytes(cfg_bytes)
);

// File: tb/sim_smb_blk_regfile.sv
module sim_smb_blk_regfile;

    localparam int Q = 10;
    localparam logic [55:0] DFLT = 56'h31003FC77FC70C;
    // {write data, expected cfg} per vector
    localparam logic [111:0] VEC [3] = '{
        {56'hFFFFFFFFFFFFFF, 56'h310F3FFF7FC7AC},
        {56'h00000000000000, 56'h31000000008004},
        {56'h006996C33CA55A, 56'h310916C33C850C}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        m_scl = 1'b1;
    logic        m_low = 1'b0;
    logic        sda_oe;
    logic        sda_line;
    logic [1:0]  strap_fs = 2'b10;
    logic        strap_swing = 1'b1;
    logic [55:0] cfg;
    int total = 0;
    int bad = 0;
    int viol = 0;
    logic prev_oe = 1'b0;

    always #10 clk = ~clk;

    assign sda_line = ~(m_low | sda_oe);

    smb_blk_regfile u0 (
        .clk(clk), .rst(rst), .scl_in(m_scl), .sda_in(sda_line), .sda_oe(sda_oe),
        .strap_fs(strap_fs), .strap_swing(strap_swing), .cfg_bytes(cfg)
    );

    // R10 monitor at the ports
    always @(posedge clk) begin
        if (!rst && sda_oe && !prev_oe && m_scl) viol++;
        prev_oe <= sda_oe;
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_low = 1'b0; m_scl = 1'b1; tick(Q);
        m_low = 1'b1; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        m_low = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_low = 1'b0; tick(Q);
    endtask

    task automatic put_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            m_low = ~b[i]; tick(Q);
            m_scl = 1'b1; tick(2 * Q);
            m_scl = 1'b0;
        end
        m_low = 1'b0; tick(Q);
        m_scl = 1'b1; tick(Q);
        acked = ~sda_line; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic get_byte(input bit give_ack, output logic [7:0] b);
        m_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            tick(Q); m_scl = 1'b1;
            tick(Q); b[i] = sda_line;
            tick(Q); m_scl = 1'b0;
        end
        m_low = give_ack; tick(Q);
        m_scl = 1'b1; tick(2 * Q);
        m_scl = 1'b0; m_low = 1'b0;
    endtask

    // acks[0]=address, [1]=command, [2]=count, [3+k]=data byte k
    task automatic wr_block(input logic [7:0] cmd, input logic [7:0] cnt, input int n,
                            input logic [63:0] data, output logic [10:0] acks);
        bit a;
        acks = '0;
        bus_start();
        put_byte(8'hD2, a); acks[0] = a;
        put_byte(cmd, a);   acks[1] = a;
        put_byte(cnt, a);   acks[2] = a;
        for (int k = 0; k < n; k++) begin
            put_byte(data[8*k +: 8], a); acks[3+k] = a;
        end
        bus_stop();
    endtask

    task automatic rd_block(input int n, output logic [7:0] cnt, output logic [63:0] data);
        bit a;
        logic [7:0] b;
        data = '1;
        bus_start();
        put_byte(8'hD3, a);
        get_byte(1'b1, cnt);
        for (int k = 0; k < n; k++) begin
            get_byte(k != n - 1, b);
            data[8*k +: 8] = b;
        end
        bus_stop();
    endtask

    initial begin
        logic [10:0] acks;
        logic [7:0]  cnt, b;
        logic [63:0] rd;
        bit a;

        tick(5);
        rst = 1'b0;
        tick(2);
        chk(cfg == DFLT, "R1 reset value", 64'(cfg), 64'(DFLT));

        strap_fs = 2'b01; strap_swing = 1'b0;
        tick(4);
        chk(cfg == DFLT, "R2 straps held after reset", 64'(cfg), 64'(DFLT));

        rd_block(7, cnt, rd);
        chk(cnt == 8'h07, "R8 byte count", 64'(cnt), 64'h07);
        chk(rd[55:0] == DFLT, "R1 R8 default readback", rd, 64'(DFLT));

        // R3: foreign address is refused and ignored
        bus_start();
        put_byte(8'hA4, a);
        chk(a == 1'b0, "R3 foreign address nack", 64'(a), 64'h0);
        put_byte(8'h00, a);
        put_byte(8'h00, a);
        bus_stop();
        chk(cfg == DFLT, "R3 foreign address no effect", 64'(cfg), 64'(DFLT));

        // vector walk: R4 R5 R8
        for (int v = 0; v < 3; v++) begin
            wr_block(8'h10 + 8'(v * 37), 8'h03 + 8'(v), 7, {8'h00, VEC[v][111:56]}, acks);
            chk(acks[9:0] == 10'h3FF, "R4 all bytes acked", 64'(acks), 64'h3FF);
            chk(cfg == VEC[v][55:0], "R5 masked register load", 64'(cfg), 64'(VEC[v][55:0]));
            rd_block(7, cnt, rd);
            chk(cnt == 8'h07, "R8 count on read", 64'(cnt), 64'h07);
            chk(rd[55:0] == VEC[v][55:0], "R8 ordered readback", rd, 64'(VEC[v][55:0]));
        end

        // R6: partial write then restart at reg0
        wr_block(8'hAA, 8'h55, 2, 64'hFFFF, acks);
        chk(cfg == 56'h310916C33CC7AC, "R6 partial write", 64'(cfg), 64'h310916C33CC7AC);
        wr_block(8'h00, 8'h00, 1, 64'h00, acks);
        chk(cfg == 56'h310916C33CC704, "R6 restart at reg0", 64'(cfg), 64'h310916C33CC704);

        // R7: eighth data byte refused
        wr_block(8'h01, 8'h08, 8, 64'hFF00000000000000, acks);
        chk(acks[10] == 1'b0, "R7 extra byte nack", 64'(acks[10]), 64'h0);
        chk(acks[9:0] == 10'h3FF, "R7 first seven acked", 64'(acks[9:0]), 64'h3FF);
        chk(cfg == 56'h31000000008004, "R7 extra byte not stored", 64'(cfg), 64'h31000000008004);

        // R9: read past reg6 yields 0xFF
        rd_block(8, cnt, rd);
        chk(rd == 64'hFF31000000008004, "R9 read past last register", rd, 64'hFF31000000008004);

        // R9: host nack after count, line released
        bus_start();
        put_byte(8'hD3, a);
        get_byte(1'b0, cnt);
        get_byte(1'b0, b);
        bus_stop();
        chk(b == 8'hFF, "R9 released after nack", 64'(b), 64'hFF);
        rd_block(7, cnt, rd);
        chk(cnt == 8'h07 && rd[55:0] == 56'h31000000008004, "R9 recovery read",
            rd, 64'h31000000008004);

        chk(viol == 0, "R10 drive starts with SCL low", 64'(viol), 64'h0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule